// File: doc/BRIEF.md
# Bus Slave Response Tracker

This block watches a shared bus from the master's side and turns the slave's three response lines (wait, error, last) into one outcome per completed data transfer: done, error, retract or burst-break. It also records what the master announces for the next cycle: a transfer type (address-only, nonsequential, sequential), an access size (byte, halfword, word), a read/write flag and an address. It then checks those announcements against what the slave has allowed.

A transfer is announced in a cycle where the bus is free, meaning no data transfer is in flight or the one in flight completes in that cycle. The announced transfer is in flight from the next cycle. Each cycle in which it is in flight, the slave responds. Wait high stretches the transfer. Wait low ends it, and error and last then select the outcome. Error and last high together mean the slave retracted the transfer. The tracker then holds a reissue flag and the retracted address until the master announces that address again as a nonsequential transfer. Last high means the next transfer must start a fresh nonsequential sequence. A sequential announcement before that happens is a protocol violation.

Outcome pulses, the completed transfer's size and direction, and the violation pulse are all registered. They appear in the cycle after the one in which the response or announcement was seen.

Top module: `bus_rsp_tracker`

## Requirements
- R1: While reset is held, every outcome pulse, the violation pulse and the reissue flag are low.
- R2: While a transfer is in flight and wait is high, no outcome pulse is raised and announcements are not taken.
- R3: A completion with error and last low raises `out_done` for exactly one cycle, the cycle after completion. `out_size` and `out_write` then carry the completed transfer's size and direction.
- R4: A completion with error high and last low raises only `out_error`.
- R5: A completion with error and last both high raises only `out_retract`. In the same cycle `reissue_req` goes high and `reissue_addr` holds the retracted transfer's address.
- R6: A completion with last high and error low raises only `out_break`.
- R7: `reissue_req` stays high until a nonsequential type (2'b10) is announced with an address equal to `reissue_addr`. It falls in the cycle after that announcement. A different address, or a sequential type, leaves it high.
- R8: A sequential type (2'b11) announced before the next nonsequential one raises `proto_viol` for one cycle. This applies from reset, and from any completion with last high (including the same cycle as that completion). A sequential announcement after a completion with last low raises no violation.
- R9: The reserved type 2'b01 raises `proto_viol` and starts no transfer.
- R10: A data transfer (type 2'b10 or 2'b11) announced with the reserved size 2'b11 raises `proto_viol`. Sizes are 2'b00 byte, 2'b01 halfword, 2'b10 word. An address-only announcement (2'b00) with size 2'b11 raises nothing.
- R11: An address-only announcement starts no transfer. Response lines have no effect while no transfer is in flight.
- R12: At most one outcome pulse is high in any cycle, and each completed data transfer produces exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_type | input | 2 | Type announced for the next cycle |
| xfer_addr | input | ADDR_W | Announced address |
| xfer_size | input | 2 | Announced access size |
| xfer_write | input | 1 | Announced direction, high for write |
| rsp_wait | input | 1 | Slave needs another cycle |
| rsp_error | input | 1 | Slave reports failure (retract with last) |
| rsp_last | input | 1 | Slave ends the burst |
| out_done | output | 1 | Pulse: transfer completed cleanly |
| out_error | output | 1 | Pulse: transfer failed |
| out_retract | output | 1 | Pulse: transfer retracted |
| out_break | output | 1 | Pulse: transfer completed, burst ended |
| out_size | output | 2 | Size of the last completed transfer |
| out_write | output | 1 | Direction of the last completed transfer |
| reissue_req | output | 1 | Retracted transfer must be reissued |
| reissue_addr | output | ADDR_W | Address to reissue |
| proto_viol | output | 1 | Pulse: illegal announcement |

## Verification
The hardest situation to reach is a sequential announcement made in the very cycle a transfer completes with last high. In that case the violation comes from the response line, not from stored state. The stimulus reaches it by completing a transfer with last high while announcing sequential in the same cycle. It then contrasts that with the same pattern after a clean completion, and with a sequential announcement placed after an intervening address-only cycle. The reissue flag is driven through near-miss announcements: another address, and the right address with a sequential type. Only then is it cleared by the exact nonsequential reissue.

// File: rtl/bus_rsp_pkg.sv
package bus_rsp_pkg;

  localparam logic [1:0] TT_IDLE = 2'b00;
  localparam logic [1:0] TT_RSVD = 2'b01;
  localparam logic [1:0] TT_NSEQ = 2'b10;
  localparam logic [1:0] TT_SEQ  = 2'b11;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;

  typedef enum logic [1:0] {
    OC_DONE    = 2'd0,
    OC_ERR     = 2'd1,
    OC_RETRACT = 2'd2,
    OC_BREAK   = 2'd3
  } outcome_e;

  // Response pair at completion -> outcome; retract outranks plain error.
  function automatic outcome_e classify(input logic err, input logic last);
    if (err && last)  return OC_RETRACT;
    else if (err)     return OC_ERR;
    else if (last)    return OC_BREAK;
    else              return OC_DONE;
  endfunction

  // Nonsequential and sequential both move data; both have bit 1 set.
  function automatic logic is_data(input logic [1:0] t);
    return t[1];
  endfunction

  // An announcement is illegal when its type is reserved, when it is
  // sequential while the burst is broken, or when a data transfer asks
  // for the reserved size.
  function automatic logic announce_bad(input logic [1:0] t,
                                        input logic [1:0] sz,
                                        input logic       broken);
    return (t == TT_RSVD) || (t == TT_SEQ && broken) ||
           (is_data(t) && sz == SZ_RSVD);
  endfunction

endpackage

// File: rtl/bus_rsp_xfer.sv
module bus_rsp_xfer
  import bus_rsp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        xfer_type,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [1:0]        xfer_size,
  input  logic              xfer_write,
  input  logic              rsp_wait,
  output logic              active,
  output logic              accept,
  output logic              complete,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        cur_size,
  output logic              cur_write
);

  assign complete = active && !rsp_wait;
  assign accept   = !active || complete;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cur_addr  <= '0;
      cur_size  <= SZ_BYTE;
      cur_write <= 1'b0;
    end else if (accept) begin
      active <= is_data(xfer_type);
      if (is_data(xfer_type)) begin
        cur_addr  <= xfer_addr;
        cur_size  <= xfer_size;
        cur_write <= xfer_write;
      end
    end
  end

endmodule

// File: rtl/bus_rsp_classify.sv
module bus_rsp_classify
  import bus_rsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       complete,
  input  logic       rsp_error,
  input  logic       rsp_last,
  input  logic [1:0] cur_size,
  input  logic       cur_write,
  output logic       out_done,
  output logic       out_error,
  output logic       out_retract,
  output logic       out_break,
  output logic [1:0] out_size,
  output logic       out_write
);

  outcome_e oc;
  assign oc = classify(rsp_error, rsp_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done    <= 1'b0;
      out_error   <= 1'b0;
      out_retract <= 1'b0;
      out_break   <= 1'b0;
      out_size    <= SZ_BYTE;
      out_write   <= 1'b0;
    end else begin
      out_done    <= complete && (oc == OC_DONE);
      out_error   <= complete && (oc == OC_ERR);
      out_retract <= complete && (oc == OC_RETRACT);
      out_break   <= complete && (oc == OC_BREAK);
      if (complete) begin
        out_size  <= cur_size;
        out_write <= cur_write;
      end
    end
  end

endmodule

// File: rtl/bus_rsp_reissue.sv
module bus_rsp_reissue
  import bus_rsp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              complete,
  input  logic              rsp_error,
  input  logic              rsp_last,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              accept,
  input  logic [1:0]        xfer_type,
  input  logic [ADDR_W-1:0] xfer_addr,
  output logic              retract_evt,
  output logic              reissue_hit,
  output logic              reissue_req,
  output logic [ADDR_W-1:0] reissue_addr
);

  assign retract_evt = complete && (classify(rsp_error, rsp_last) == OC_RETRACT);
  assign reissue_hit = reissue_req && accept && (xfer_type == TT_NSEQ) &&
                       (xfer_addr == reissue_addr);

  // A new retract in the same cycle wins over a clearing announcement.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reissue_req  <= 1'b0;
      reissue_addr <= '0;
    end else if (retract_evt) begin
      reissue_req  <= 1'b1;
      reissue_addr <= cur_addr;
    end else if (reissue_hit) begin
      reissue_req  <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_rsp_seqguard.sv
module bus_rsp_seqguard
  import bus_rsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       complete,
  input  logic       rsp_last,
  input  logic [1:0] xfer_type,
  input  logic [1:0] xfer_size,
  output logic       broken_now,
  output logic       bad_announce,
  output logic       proto_viol
);

  logic last_pending;

  // The burst is broken by a stored last or by a last arriving right now.
  assign broken_now   = last_pending || (complete && rsp_last);
  assign bad_announce = accept && announce_bad(xfer_type, xfer_size, broken_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pending <= 1'b1;
      proto_viol   <= 1'b0;
    end else begin
      proto_viol <= bad_announce;
      if (accept && xfer_type == TT_NSEQ)
        last_pending <= 1'b0;
      else if (complete && rsp_last)
        last_pending <= 1'b1;
    end
  end

endmodule

// File: rtl/bus_rsp_tracker.sv
module bus_rsp_tracker
  import bus_rsp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        xfer_type,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic [1:0]        xfer_size,
  input  logic              xfer_write,
  input  logic              rsp_wait,
  input  logic              rsp_error,
  input  logic              rsp_last,
  output logic              out_done,
  output logic              out_error,
  output logic              out_retract,
  output logic              out_break,
  output logic [1:0]        out_size,
  output logic              out_write,
  output logic              reissue_req,
  output logic [ADDR_W-1:0] reissue_addr,
  output logic              proto_viol
);

  logic              active;
  logic              accept;
  logic              complete;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        cur_size;
  logic              cur_write;
  logic              retract_evt;
  logic              reissue_hit;
  logic              broken_now;
  logic              bad_announce;

  bus_rsp_xfer #(.ADDR_W(ADDR_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .xfer_type(xfer_type), .xfer_addr(xfer_addr),
    .xfer_size(xfer_size), .xfer_write(xfer_write),
    .rsp_wait(rsp_wait),
    .active(active), .accept(accept), .complete(complete),
    .cur_addr(cur_addr), .cur_size(cur_size), .cur_write(cur_write)
  );

  bus_rsp_classify u_class (
    .clk(clk), .rst_n(rst_n),
    .complete(complete), .rsp_error(rsp_error), .rsp_last(rsp_last),
    .cur_size(cur_size), .cur_write(cur_write),
    .out_done(out_done), .out_error(out_error),
    .out_retract(out_retract), .out_break(out_break),
    .out_size(out_size), .out_write(out_write)
  );

  bus_rsp_reissue #(.ADDR_W(ADDR_W)) u_reissue (
    .clk(clk), .rst_n(rst_n),
    .complete(complete), .rsp_error(rsp_error), .rsp_last(rsp_last),
    .cur_addr(cur_addr), .accept(accept),
    .xfer_type(xfer_type), .xfer_addr(xfer_addr),
    .retract_evt(retract_evt), .reissue_hit(reissue_hit),
    .reissue_req(reissue_req), .reissue_addr(reissue_addr)
  );

  bus_rsp_seqguard u_guard (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .complete(complete), .rsp_last(rsp_last),
    .xfer_type(xfer_type), .xfer_size(xfer_size),
    .broken_now(broken_now), .bad_announce(bad_announce),
    .proto_viol(proto_viol)
  );

endmodule

// File: rtl/bus_rsp_tracker_chk.sv
module bus_rsp_tracker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        xfer_type,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              rsp_wait,
  input logic              active,
  input logic              accept,
  input logic              out_done,
  input logic              out_error,
  input logic              out_retract,
  input logic              out_break,
  input logic              reissue_req,
  input logic [ADDR_W-1:0] reissue_addr,
  input logic              proto_viol
);

  logic any_out;
  assign any_out = out_done || out_error || out_retract || out_break;

  // R12
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_done, out_error, out_retract, out_break}));

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rsp_wait) |=> !any_out);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(active));

  // R5
  retract_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reissue_req) |-> out_retract);

  // R7
  reissue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reissue_req) |-> ($past(accept) && $past(xfer_type) == 2'b10 &&
                            $past(xfer_addr) == $past(reissue_addr)));

  // R9
  rsvd_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && xfer_type == 2'b01) |=> proto_viol);

endmodule

bind bus_rsp_tracker bus_rsp_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .xfer_type(xfer_type), .xfer_addr(xfer_addr), .rsp_wait(rsp_wait),
  .active(active), .accept(accept),
  .out_done(out_done), .out_error(out_error),
  .out_retract(out_retract), .out_break(out_break),
  .reissue_req(reissue_req), .reissue_addr(reissue_addr),
  .proto_viol(proto_viol)
);

// File: tb/bus_rsp_tracker_tb.sv
module bus_rsp_tracker_tb;

  localparam int AW = 32;
  localparam logic [1:0] T_IDLE = 2'b00, T_RSVD = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;
  localparam logic [3:0] O_NONE = 4'b0000, O_DONE = 4'b1000, O_ERR = 4'b0100,
                         O_RET  = 4'b0010, O_BRK  = 4'b0001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    xfer_type = 2'b00;
  logic [AW-1:0] xfer_addr = '0;
  logic [1:0]    xfer_size = 2'b00;
  logic          xfer_write = 1'b0;
  logic          rsp_wait = 1'b0, rsp_error = 1'b0, rsp_last = 1'b0;
  logic          out_done, out_error, out_retract, out_break, out_write;
  logic [1:0]    out_size;
  logic          reissue_req, proto_viol;
  logic [AW-1:0] reissue_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_rsp_tracker #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .xfer_type(xfer_type), .xfer_addr(xfer_addr),
    .xfer_size(xfer_size), .xfer_write(xfer_write),
    .rsp_wait(rsp_wait), .rsp_error(rsp_error), .rsp_last(rsp_last),
    .out_done(out_done), .out_error(out_error),
    .out_retract(out_retract), .out_break(out_break),
    .out_size(out_size), .out_write(out_write),
    .reissue_req(reissue_req), .reissue_addr(reissue_addr),
    .proto_viol(proto_viol)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive away from the edge, sample just after it.
  task automatic cyc(input logic [1:0] t, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic wr, input logic w, input logic e, input logic l);
    @(negedge clk);
    xfer_type = t; xfer_addr = a; xfer_size = sz; xfer_write = wr;
    rsp_wait = w; rsp_error = e; rsp_last = l;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {out_done, out_error, out_retract, out_break};
    chk(act == exp, tag, act, exp);
  endtask

  task automatic expect_viol(input string tag, input logic exp);
    chk(proto_viol == exp, tag, proto_viol, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_out("R1 outcomes in reset", O_NONE);
    chk(reissue_req == 1'b0, "R1 reissue in reset", reissue_req, 0);
    expect_viol("R1 viol in reset", 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_done;
    cyc(T_NSEQ, 32'h100, 2'b10, 1'b1, 1'b0, 1'b1, 1'b1);
    expect_out("R11 responses ignored while idle", O_NONE);
    expect_viol("R8 nonseq after reset legal", 1'b0);
    cyc(T_IDLE, '0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 R12 clean completion", O_DONE);
    chk(out_size == 2'b10, "R3 size word", out_size, 2'b10);
    chk(out_write == 1'b1, "R3 write dir", out_write, 1);
    expect_viol("R10 addr-only rsvd size legal", 1'b0);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R11 addr-only starts nothing", O_NONE);
  endtask

  task automatic t_wait;
    cyc(T_NSEQ, 32'h200, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_out("R2 wait cycle 1", O_NONE);
    cyc(T_RSVD, '0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1);
    expect_out("R2 wait cycle 2", O_NONE);
    expect_viol("R2 announcement not taken in wait", 1'b0);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R2 completes after wait", O_DONE);
    chk(out_size == 2'b01, "R3 size halfword", out_size, 2'b01);
    chk(out_write == 1'b0, "R3 read dir", out_write, 0);
  endtask

  task automatic t_error;
    cyc(T_NSEQ, 32'h240, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R4 error outcome", O_ERR);
    chk(reissue_req == 1'b0, "R4 error no reissue", reissue_req, 0);
  endtask

  task automatic t_break;
    // last with sequential announced in the same cycle
    cyc(T_NSEQ, 32'h400, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(T_SEQ, 32'h404, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out("R6 break outcome", O_BRK);
    expect_viol("R8 seq in same cycle as last", 1'b1);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R12 illegal seq still completes once", O_DONE);
    expect_viol("R8 viol is one pulse", 1'b0);
    // sequential after clean completion is legal
    cyc(T_NSEQ, 32'h500, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(T_SEQ, 32'h504, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_viol("R8 seq after clean completion", 1'b0);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out("R6 break at end of burst", O_BRK);
    // address-only in between does not mend the burst
    cyc(T_SEQ, 32'h508, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_viol("R8 seq after last and addr-only", 1'b1);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 seq transfer completes", O_DONE);
  endtask

  task automatic t_retract;
    cyc(T_NSEQ, 32'h300, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_out("R5 retract outcome", O_RET);
    chk(reissue_req == 1'b1, "R5 reissue set", reissue_req, 1);
    chk(reissue_addr == 32'h300, "R5 reissue addr", reissue_addr, 32'h300);
    cyc(T_NSEQ, 32'h304, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(reissue_req == 1'b1, "R7 other addr keeps flag", reissue_req, 1);
    cyc(T_SEQ, 32'h300, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(reissue_req == 1'b1, "R7 seq type keeps flag", reissue_req, 1);
    expect_viol("R8 seq after clean completion", 1'b0);
    cyc(T_NSEQ, 32'h300, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(reissue_req == 1'b0, "R7 exact reissue clears", reissue_req, 0);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 reissued transfer done", O_DONE);
  endtask

  task automatic t_reserved;
    cyc(T_RSVD, 32'h600, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_viol("R9 reserved type", 1'b1);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R9 reserved type starts nothing", O_NONE);
    cyc(T_NSEQ, 32'h700, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_viol("R10 reserved size on data", 1'b1);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R10 transfer still completes", O_DONE);
    expect_viol("R10 pulse ends", 1'b0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    cyc(T_SEQ, 32'h10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_viol("R8 seq first after reset", 1'b1);
    cyc(T_IDLE, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 first transfer completes", O_DONE);
    t_done;
    t_wait;
    t_error;
    t_break;
    t_retract;
    t_reserved;
    finish_run;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run;
  end

endmodule